// File: doc/BRIEF.md
# Source-Routed Crossbar Router for a Time-Slotted Network

This block is one switching node of an on-chip network where every link slot is fixed ahead of time by a global schedule. It has four neighbour links, numbered north 0, east 1, south 2 and west 3, plus a local port numbered 4. Each input carries one flit per clock. A flit has a valid bit, a type bit (1 = header, 0 = payload) and a data word.

A packet is a header flit followed by any number of payload flits. The header's data word holds the whole path as a chain of 2-bit hop codes, with the least significant pair used first. Every input has its own route decoder. The decoder reads the low pair of a header, records the output it selects, and forwards the header with its data shifted right by two. Each later payload flit on that input follows the recorded output. A code equal to the input's own link number sends the packet back the way it came, so that code means "deliver to the local port". The local input always uses the code as the output number.

The schedule is meant to keep two inputs from ever reaching one output together. The router therefore has no arbitration and no queues, only three register stages from input to output. If two inputs do reach one output together, the lowest-numbered input wins and a sticky error flag is raised.

Top module: `tdm_router`

## Requirements
- R1: A flit presented at an input before clock edge k reaches its output just after edge k+2 (three register stages), and no output shows it earlier.
- R2: A valid header on input p whose low 2-bit code is c leaves on output c. When p is 0 to 3 and c equals p, it leaves on the local output 4 instead. The local input 4 always uses output c.
- R3: A forwarded header keeps its type bit set and has its data shifted right by two, with zeros in the top two bits.
- R4: Each valid payload flit after a header on the same input leaves on the output that header chose, with its data and type bit (0) unchanged.
- R5: An invalid flit ends the packet on its input. A payload flit that arrives with no packet open (after an invalid flit, or after reset with no header yet) produces no output.
- R6: A new header on an input that already has a packet open switches all following payload flits to the new header's output.
- R7: When two or more flits reach one output in the same cycle, only the one from the lowest-numbered input leaves. The others are discarded.
- R8: The error flag rises in the same cycle that such a clash reaches the outputs, and it stays high until reset.
- R9: While reset is low, and on the first edge after it is released, every output is invalid and the error flag is low.
- R10: An output that carries no flit shows valid 0, type 0 and data 0.
- R11: Flits bound for different outputs pass in the same cycle without affecting one another, so all five outputs can be busy at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lnk_in_vld | input | 5 | Per-input flit valid |
| lnk_in_hdr | input | 5 | Per-input type bit, 1 = header |
| lnk_in_data | input | 5x32 | Per-input flit data |
| lnk_out_vld | output | 5 | Per-output flit valid |
| lnk_out_hdr | output | 5 | Per-output type bit |
| lnk_out_data | output | 5x32 | Per-output flit data |
| route_err | output | 1 | Sticky flag for an output clash |

## Verification
The assertions assume that reset is asserted before the first check and that the input valid bits are never unknown after reset. On that basis, an output flit always traces back to some valid input three cycles earlier. A rise of the error flag is only allowed when at least two inputs were valid three cycles before. In the main random phase, each candidate flit is first resolved against the outputs already claimed in that cycle, and a flit that would clash is turned into an idle slot. Clashes appear only in one directed case and in a final random phase that lets them through on purpose.

// File: rtl/tdm_rt_pkg.sv
`timescale 1ns/1ps
package tdm_rt_pkg;
   // hop code width is fixed by the header route format
   localparam int unsigned CODE_W   = 2;
   localparam int unsigned NUM_DIR  = 1 << CODE_W;
   localparam int unsigned NUM_PORT = NUM_DIR + 1;
   localparam int unsigned LOCAL_ID = NUM_DIR;

   typedef logic [NUM_PORT-1:0] port_mask_t;

   // Turn a hop code into a one-hot output mask. A code pointing back at
   // the arrival link means local delivery.
   function automatic port_mask_t route_mask(input logic [CODE_W-1:0] code,
                                             input int unsigned arrive);
      port_mask_t m;
      m = '0;
      if (arrive < NUM_DIR && int'(unsigned'(code)) == int'(arrive))
         m[LOCAL_ID] = 1'b1;
      else
         m[code] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/tdm_hpu.sv
`timescale 1ns/1ps
// Per-input route decoder: stage 2 of the router pipeline.
module tdm_hpu
   import tdm_rt_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PORT_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              f_vld,
   input  logic              f_hdr,
   input  logic [DATA_W-1:0] f_data,
   output logic              q_vld,
   output logic              q_hdr,
   output logic [DATA_W-1:0] q_data,
   output port_mask_t        q_sel
);
   generate
      if (PORT_ID >= NUM_PORT) begin : g_bad_id
         $error("tdm_hpu: PORT_ID out of range");
      end
      if (DATA_W <= CODE_W) begin : g_bad_w
         $error("tdm_hpu: DATA_W too small for a hop code");
      end
   endgenerate

   logic              bound_q, bound_d;
   port_mask_t        sel_q, sel_d;
   logic              fwd;
   logic [DATA_W-1:0] fwd_data;

   always_comb begin
      bound_d  = bound_q;
      sel_d    = sel_q;
      fwd      = 1'b0;
      fwd_data = f_data;
      if (!f_vld) begin
         bound_d = 1'b0;
      end else if (f_hdr) begin
         bound_d  = 1'b1;
         sel_d    = route_mask(f_data[CODE_W-1:0], PORT_ID);
         fwd      = 1'b1;
         fwd_data = f_data >> CODE_W;
      end else begin
         fwd = bound_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bound_q <= 1'b0;
         sel_q   <= '0;
         q_vld   <= 1'b0;
         q_hdr   <= 1'b0;
         q_data  <= '0;
         q_sel   <= '0;
      end else begin
         bound_q <= bound_d;
         sel_q   <= sel_d;
         q_vld   <= fwd;
         q_hdr   <= fwd & f_hdr;
         q_data  <= fwd ? fwd_data : '0;
         q_sel   <= fwd ? sel_d : '0;
      end
   end
endmodule

// File: rtl/tdm_xbar.sv
`timescale 1ns/1ps
// Crossbar with fixed lowest-index priority: stage 3 of the router pipeline.
module tdm_xbar
   import tdm_rt_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_PORT-1:0]              r_vld,
   input  logic [NUM_PORT-1:0]              r_hdr,
   input  logic [NUM_PORT-1:0][DATA_W-1:0]  r_data,
   input  port_mask_t [NUM_PORT-1:0]        r_sel,
   output logic [NUM_PORT-1:0]              o_vld,
   output logic [NUM_PORT-1:0]              o_hdr,
   output logic [NUM_PORT-1:0][DATA_W-1:0]  o_data,
   output logic                             clash_sticky
);
   logic [NUM_PORT-1:0] clash;

   for (genvar o = 0; o < NUM_PORT; o++) begin : g_out
      port_mask_t        hit, win;
      logic              w_hdr;
      logic [DATA_W-1:0] w_data;
      logic              v_q, h_q;
      logic [DATA_W-1:0] d_q;

      always_comb begin
         for (int i = 0; i < NUM_PORT; i++) hit[i] = r_vld[i] & r_sel[i][o];
         win    = hit & (~hit + port_mask_t'(1));
         w_hdr  = |(win & r_hdr);
         w_data = '0;
         for (int i = 0; i < NUM_PORT; i++) w_data = w_data | ({DATA_W{win[i]}} & r_data[i]);
      end

      assign clash[o] = |(hit & ~win);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            h_q <= 1'b0;
            d_q <= '0;
         end else begin
            v_q <= |hit;
            h_q <= w_hdr;
            d_q <= w_data;
         end
      end

      assign o_vld[o]  = v_q;
      assign o_hdr[o]  = h_q;
      assign o_data[o] = d_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clash_sticky <= 1'b0;
      else        clash_sticky <= clash_sticky | (|clash);
   end
endmodule

// File: rtl/tdm_router.sv
`timescale 1ns/1ps
module tdm_router
   import tdm_rt_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_PORT-1:0]              lnk_in_vld,
   input  logic [NUM_PORT-1:0]              lnk_in_hdr,
   input  logic [NUM_PORT-1:0][DATA_W-1:0]  lnk_in_data,
   output logic [NUM_PORT-1:0]              lnk_out_vld,
   output logic [NUM_PORT-1:0]              lnk_out_hdr,
   output logic [NUM_PORT-1:0][DATA_W-1:0]  lnk_out_data,
   output logic                             route_err
);
   generate
      if (DATA_W < 2 * CODE_W) begin : g_bad_w
         $error("tdm_router: DATA_W must hold at least two hop codes");
      end
   endgenerate

   logic [NUM_PORT-1:0]             s1_vld, s1_hdr;
   logic [NUM_PORT-1:0][DATA_W-1:0] s1_data;
   logic [NUM_PORT-1:0]             s2_vld, s2_hdr;
   logic [NUM_PORT-1:0][DATA_W-1:0] s2_data;
   port_mask_t [NUM_PORT-1:0]       s2_sel;

   for (genvar p = 0; p < NUM_PORT; p++) begin : g_in
      // stage 1: link capture register
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_vld[p]  <= 1'b0;
            s1_hdr[p]  <= 1'b0;
            s1_data[p] <= '0;
         end else begin
            s1_vld[p]  <= lnk_in_vld[p];
            s1_hdr[p]  <= lnk_in_hdr[p];
            s1_data[p] <= lnk_in_data[p];
         end
      end

      // stage 2: route decode per input
      tdm_hpu #(.DATA_W(DATA_W), .PORT_ID(p)) u_hpu (
         .clk    (clk),
         .rst_n  (rst_n),
         .f_vld  (s1_vld[p]),
         .f_hdr  (s1_hdr[p]),
         .f_data (s1_data[p]),
         .q_vld  (s2_vld[p]),
         .q_hdr  (s2_hdr[p]),
         .q_data (s2_data[p]),
         .q_sel  (s2_sel[p])
      );
   end

   // stage 3: crossbar and output register
   tdm_xbar #(.DATA_W(DATA_W)) u_xbar (
      .clk          (clk),
      .rst_n        (rst_n),
      .r_vld        (s2_vld),
      .r_hdr        (s2_hdr),
      .r_data       (s2_data),
      .r_sel        (s2_sel),
      .o_vld        (lnk_out_vld),
      .o_hdr        (lnk_out_hdr),
      .o_data       (lnk_out_data),
      .clash_sticky (route_err)
   );
endmodule

// File: rtl/tdm_router_chk.sv
`timescale 1ns/1ps
module tdm_router_chk
   import tdm_rt_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [NUM_PORT-1:0]              in_vld,
   input logic [NUM_PORT-1:0]              out_vld,
   input logic [NUM_PORT-1:0]              out_hdr,
   input logic [NUM_PORT-1:0][DATA_W-1:0]  out_data,
   input logic                             err
);
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R8

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> ($countones($past(in_vld, 3)) >= 2)); // R7

   for (genvar o = 0; o < NUM_PORT; o++) begin : g_port
      AST_OUT_SOURCED: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld[o] |-> ($past(in_vld, 3) != '0)); // R1

      AST_HDR_SHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
         (out_vld[o] && out_hdr[o]) |-> (out_data[o][DATA_W-1 -: CODE_W] == '0)); // R3

      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !out_vld[o] |-> (!out_hdr[o] && out_data[o] == '0)); // R10
   end
endmodule

bind tdm_router tdm_router_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (lnk_in_vld),
   .out_vld  (lnk_out_vld),
   .out_hdr  (lnk_out_hdr),
   .out_data (lnk_out_data),
   .err      (route_err)
);

// File: tb/tdm_router_tb.sv
`timescale 1ns/1ps
module tdm_router_tb;
   localparam int NP = 5;
   localparam int DW = 32;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [NP-1:0]           in_vld = '0, in_hdr = '0;
   logic [NP-1:0][DW-1:0]   in_data = '0;
   logic [NP-1:0]           out_vld, out_hdr;
   logic [NP-1:0][DW-1:0]   out_data;
   logic                    route_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench model state
   bit                      act [NP];
   int                      dst_m [NP];
   bit                      err_m;
   logic [NP-1:0]           pv [3], ph [3], pc [3];
   logic [NP-1:0][DW-1:0]   pd [3];
   logic                    pe [3];

   always #2 clk = ~clk;

   tdm_router #(.DATA_W(DW)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .lnk_in_vld   (in_vld),
      .lnk_in_hdr   (in_hdr),
      .lnk_in_data  (in_data),
      .lnk_out_vld  (out_vld),
      .lnk_out_hdr  (out_hdr),
      .lnk_out_data (out_data),
      .route_err    (route_err)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] actual, input logic [63:0] expect_v);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actual, expect_v);
      end
   endtask

   // R2: hop code decode, U-turn code on links 0..3 means local output 4
   function automatic int dest_of(input logic [1:0] code, input int p);
      if (p < 4 && int'(code) == p) return 4;
      return int'(code);
   endfunction

   task automatic clear_model();
      for (int p = 0; p < NP; p++) begin
         act[p] = 1'b0;
         dst_m[p] = 0;
      end
      err_m = 1'b0;
      for (int k = 0; k < 3; k++) begin
         pv[k] = '0; ph[k] = '0; pc[k] = '0; pd[k] = '0; pe[k] = 1'b0;
      end
   endtask

   task automatic compare();
      for (int o = 0; o < NP; o++) begin
         string tg;
         if (!pv[2][o])     tg = "R5";
         else if (pc[2][o]) tg = "R7";
         else if (ph[2][o]) tg = "R2";
         else               tg = "R4";
         check(out_vld[o] === pv[2][o], tg, $sformatf("out%0d valid", o),
               64'(out_vld[o]), 64'(pv[2][o]));
         if (pv[2][o]) begin
            check(out_hdr[o] === ph[2][o], tg, $sformatf("out%0d type", o),
                  64'(out_hdr[o]), 64'(ph[2][o]));
            check(out_data[o] === pd[2][o], ph[2][o] ? "R3" : tg, $sformatf("out%0d data", o),
                  64'(out_data[o]), 64'(pd[2][o]));
         end else begin
            check(out_hdr[o] === 1'b0 && out_data[o] === '0, "R10", $sformatf("out%0d idle", o),
                  64'(out_data[o]), 64'(0));
         end
      end
      check(route_err === pe[2], "R8", "error flag", 64'(route_err), 64'(pe[2]));
   endtask

   // one cycle: compare outputs due now, drive new inputs, advance model
   task automatic cycle(input logic [NP-1:0] v, input logic [NP-1:0] h,
                        input logic [NP-1:0][DW-1:0] d);
      logic [NP-1:0]         rv, rh, ev, eh, ec;
      logic [NP-1:0][DW-1:0] rd, ed;
      int                    rdst [NP];
      int                    cnt;
      @(negedge clk);
      compare();
      in_vld = v; in_hdr = h; in_data = d;
      for (int p = 0; p < NP; p++) begin
         rv[p] = 1'b0; rh[p] = 1'b0; rd[p] = '0; rdst[p] = 0;
         if (!v[p]) act[p] = 1'b0;
         else if (h[p]) begin
            dst_m[p] = dest_of(d[p][1:0], p);
            act[p] = 1'b1;
            rv[p] = 1'b1; rh[p] = 1'b1; rd[p] = d[p] >> 2; rdst[p] = dst_m[p];
         end else if (act[p]) begin
            rv[p] = 1'b1; rd[p] = d[p]; rdst[p] = dst_m[p];
         end
      end
      ev = '0; eh = '0; ed = '0; ec = '0;
      for (int o = 0; o < NP; o++) begin
         cnt = 0;
         for (int p = 0; p < NP; p++) begin
            if (rv[p] && rdst[p] == o) begin
               if (cnt == 0) begin ev[o] = 1'b1; eh[o] = rh[p]; ed[o] = rd[p]; end
               cnt++;
            end
         end
         if (cnt > 1) begin ec[o] = 1'b1; err_m = 1'b1; end
      end
      pv[2] = pv[1]; ph[2] = ph[1]; pc[2] = pc[1]; pd[2] = pd[1]; pe[2] = pe[1];
      pv[1] = pv[0]; ph[1] = ph[0]; pc[1] = pc[0]; pd[1] = pd[0]; pe[1] = pe[0];
      pv[0] = ev;    ph[0] = eh;    pc[0] = ec;    pd[0] = ed;    pe[0] = err_m;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cycle('0, '0, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_vld = '0; in_hdr = '0; in_data = '0;
      clear_model();
      repeat (3) @(negedge clk);
      check(out_vld === '0 && route_err === 1'b0, "R9", "state in reset",
            64'(out_vld), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(out_vld === '0 && out_hdr === '0, "R9", "outputs after release", 64'(out_vld), 64'(0));
      check(route_err === 1'b0, "R9", "error after release", 64'(route_err), 64'(0));
   endtask

   task automatic rand_cycle(input bit allow_clash);
      logic [NP-1:0]         v, h, used;
      logic [NP-1:0][DW-1:0] d;
      int r, dst;
      used = '0;
      for (int p = 0; p < NP; p++) begin
         r = int'($urandom % 8);
         d[p] = $urandom;
         v[p] = (r >= 2);
         h[p] = (r == 2 || r == 3);
         dst = -1;
         if (v[p] && h[p]) dst = dest_of(d[p][1:0], p);
         else if (v[p] && act[p]) dst = dst_m[p];
         if (dst >= 0) begin
            if (used[dst] && !allow_clash) begin v[p] = 1'b0; h[p] = 1'b0; end
            else used[dst] = 1'b1;
         end
      end
      cycle(v, h, d);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [NP-1:0]         dv, dh;
      logic [NP-1:0][DW-1:0] dd;
      void'($urandom(32'h00C0FFEE));
      clear_model();
      do_reset();

      // R1: one header, east input, code 2 -> south output
      dv = '0; dh = '0; dd = '0;
      dv[1] = 1'b1; dh[1] = 1'b1; dd[1] = 32'h1234_5676;
      cycle(dv, dh, dd);
      idle(1);
      check(out_vld === '0, "R1", "no output one cycle after", 64'(out_vld), 64'(0));
      idle(1);
      check(out_vld === '0, "R1", "no output two cycles after", 64'(out_vld), 64'(0));
      idle(1);
      check(out_vld === 5'b00100 && out_data[2] === 32'h048D_159D, "R1", "arrives third cycle",
            64'(out_data[2]), 64'h048D_159D);
      idle(2);

      // R4 / R5 / R6: local input packet, break, orphan payload, re-route
      dv = '0; dh = '0; dd = '0;
      dv[4] = 1'b1; dh[4] = 1'b1; dd[4] = 32'hA5A5_0001;
      cycle(dv, dh, dd);
      dh[4] = 1'b0;
      dd[4] = 32'h11; cycle(dv, dh, dd);
      dd[4] = 32'h22; cycle(dv, dh, dd);
      dd[4] = 32'h33; cycle(dv, dh, dd);
      idle(1);
      dd[4] = 32'h44; cycle(dv, dh, dd);
      dh[4] = 1'b1; dd[4] = 32'h0000_0F03; cycle(dv, dh, dd);
      dh[4] = 1'b0;
      dd[4] = 32'h55; cycle(dv, dh, dd);
      dd[4] = 32'h66; cycle(dv, dh, dd);
      idle(3);
      check(out_vld === 5'b01000 && out_data[3] === 32'h66, "R6", "payload follows new header",
            64'(out_vld), 64'(5'b01000));
      idle(2);

      // R11 + R2 local eject: all five outputs busy together
      dv = '1; dh = '1;
      dd[0] = 32'hC0DE_0000; dd[1] = 32'h0000_0002; dd[2] = 32'h0000_0003;
      dd[3] = 32'h0000_0000; dd[4] = 32'h0000_0001;
      cycle(dv, dh, dd);
      idle(3);
      check(out_vld === 5'b11111, "R11", "five parallel flits", 64'(out_vld), 64'(5'b11111));
      check(out_data[4] === 32'h3037_8000, "R2", "U-turn code goes local",
            64'(out_data[4]), 64'h3037_8000);
      idle(2);

      // R7 / R8: east and west both to north
      dv = '0; dh = '0; dd = '0;
      dv[1] = 1'b1; dh[1] = 1'b1; dd[1] = 32'h0000_1110;
      dv[3] = 1'b1; dh[3] = 1'b1; dd[3] = 32'h0000_2220;
      cycle(dv, dh, dd);
      idle(3);
      check(out_vld === 5'b00001 && out_data[0] === 32'h444, "R7", "lower input wins",
            64'(out_data[0]), 64'h444);
      check(route_err === 1'b1, "R8", "flag set on clash", 64'(route_err), 64'(1));
      idle(4);
      check(route_err === 1'b1, "R8", "flag held", 64'(route_err), 64'(1));
      do_reset();

      for (int k = 0; k < 3000; k++) rand_cycle(1'b0);
      idle(3);
      do_reset();
      for (int k = 0; k < 2000; k++) rand_cycle(1'b1);
      idle(3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule